// File: doc/BRIEF.md
# Link Test Frame Generator and Bit-Error Checker

This block produces built-in test frames for a 120-bit link frame path and checks frames coming back over the same path for bit errors. Each clock cycle is one frame. The transmit side always emits a frame that starts with a fixed 4-bit header. The rest of the frame carries one of three payloads, picked by a 2-bit select: a constant alternating nibble word, a running 30-bit frame counter packed into four fields, or a 7-bit pseudo-random value copied sixteen times behind a zero nibble.

The receive side is active only while the constant payload is selected. For every valid received frame it counts the payload bits that differ from the constant word. It adds that number to an error total that stops at all ones and can be cleared synchronously. A small state machine holds the selected mode. It has three states: FIXED, COUNT and PRBS. From any state, a select of 00 or 11 goes to FIXED, 01 goes to COUNT and 10 goes to PRBS. Reset enters FIXED. The transmit format and the checker enable are both decoded from this state.

Top module: `link_pattern_unit`

## Requirements
- R1: Bits [119:116] of every transmitted frame hold the header 4'b0101 in all modes, including during reset.
- R2: The select encoding is 00 for the constant payload, 01 for the counter payload, 10 for the PRBS payload and 11 for the constant payload. A select value sampled at a clock edge sets the mode, and the frame format of that mode appears right after that edge.
- R3: In constant mode, bits [115:0] equal 116'hAAA_BBBB_AAAA_BBBB_AAAA_BBBB_AAAA_BB.
- R4: In counter mode, the payload is a 30-bit counter C laid out as C[25:0] at [115:90], then C at [89:60], at [59:30] and at [29:0]. C is 0 in reset, adds 1 on every clock edge in every mode, and wraps at 2^30.
- R5: In PRBS mode, bits [115:112] are zero and the 7-bit state P is repeated 16 times, copy k sitting at bits [7k+6:7k].
- R6: P is 7'h7F in reset and moves to {P[5:0], P[6]^P[5]} (x^7+x^6+1) on every clock edge in every mode.
- R7: In constant mode with rx_valid high, the error count grows at the next edge by the number of bits in rx_frame[115:0] that differ from the constant payload. Header bits [119:116] of the received frame are ignored.
- R8: With rx_valid low, the error count does not change.
- R9: In counter or PRBS mode, the error count does not change, whatever the received frame is.
- R10: The error count saturates at all ones and stays there until it is cleared.
- R11: err_clear sets the count to zero at the next edge and takes priority over any accumulation in the same cycle.
- R12: In reset, the count is zero and the mode is the constant payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock, one frame per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_sel | input | 2 | Payload select |
| tx_frame | output | 120 | Generated test frame |
| rx_frame | input | 120 | Received frame to check |
| rx_valid | input | 1 | rx_frame holds a frame this cycle |
| err_clear | input | 1 | Synchronous clear of the error count |
| err_count | output | ERR_W | Saturating payload bit-error total |

## Verification
The checker is fed with several kinds of received frame:
- A clean copy of the constant word, which shows that matching payloads add nothing.
- Copies with a few random bit flips, which show that the count equals the flip count.
- Frames that differ only in the header, which show that bits [119:116] are ignored.
- Fully inverted frames, which push the total to saturation.

Random mode changes separate the three transmit formats from each other. They also show that the counter and PRBS state keep advancing while another payload is selected. Valid or mismatching frames sent while the checker is idle show that R8 and R9 hold. A clear asserted together with a mismatching valid frame shows the priority stated in R11.

// File: rtl/lpu_pkg.sv
package lpu_pkg;
    localparam int FRAME_W  = 120;
    localparam int HDR_W    = 4;
    localparam int PAY_W    = FRAME_W - HDR_W;
    localparam int CTR_W    = 30;
    localparam int CTR_LO_W = 26;
    localparam int PRBS_W   = 7;
    localparam int PRBS_REP = 16;
    localparam int PC_W     = $clog2(PAY_W + 1);

    localparam logic [HDR_W-1:0]  HDR_VAL   = 4'b0101;
    localparam logic [PAY_W-1:0]  FIXED_PAY = 116'hAAA_BBBB_AAAA_BBBB_AAAA_BBBB_AAAA_BB;
    localparam logic [PRBS_W-1:0] PRBS_SEED = 7'h7F;

    typedef enum logic [1:0] {
        MODE_FIXED = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_PRBS  = 2'd2
    } mode_e;

    function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
        return {s[PRBS_W-2:0], s[6] ^ s[5]};
    endfunction

    function automatic logic [PC_W-1:0] ones_in(input logic [PAY_W-1:0] v);
        logic [PC_W-1:0] n;
        n = '0;
        for (int i = 0; i < PAY_W; i++) n = n + PC_W'(v[i]);
        return n;
    endfunction
endpackage

// File: rtl/lpu_ctrl.sv
module lpu_ctrl
    import lpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pat_sel,
    output mode_e      mode_q,
    output logic       chk_en
);
    mode_e state_q, state_d;

    // Next-state: every state goes to the mode named by pat_sel
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_FIXED, MODE_COUNT, MODE_PRBS: begin
                unique case (pat_sel)
                    2'b01:   state_d = MODE_COUNT;
                    2'b10:   state_d = MODE_PRBS;
                    default: state_d = MODE_FIXED;
                endcase
            end
            default: state_d = MODE_FIXED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_FIXED;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        chk_en = 1'b0;
        unique case (state_q)
            MODE_FIXED: chk_en = 1'b1;
            MODE_COUNT: chk_en = 1'b0;
            MODE_PRBS:  chk_en = 1'b0;
            default:    chk_en = 1'b0;
        endcase
    end

    assign mode_q = state_q;
endmodule

// File: rtl/lpu_gen.sv
module lpu_gen
    import lpu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  mode_e              mode,
    output logic [FRAME_W-1:0] frame
);
    localparam int PRBS_SPAN = PRBS_W * PRBS_REP;

    logic [CTR_W-1:0]     ctr_q;
    logic [PRBS_W-1:0]    prbs_q;
    logic [PRBS_SPAN-1:0] prbs_rep;
    logic [PAY_W-1:0]     ctr_pay, prbs_pay;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q  <= '0;
            prbs_q <= PRBS_SEED;
        end else begin
            ctr_q  <= ctr_q + 1'b1;
            prbs_q <= prbs_step(prbs_q);
        end
    end

    for (genvar k = 0; k < PRBS_REP; k++) begin : g_rep
        assign prbs_rep[k*PRBS_W +: PRBS_W] = prbs_q;
    end

    assign ctr_pay  = {ctr_q[CTR_LO_W-1:0], ctr_q, ctr_q, ctr_q};
    assign prbs_pay = {{(PAY_W-PRBS_SPAN){1'b0}}, prbs_rep};

    always_comb begin
        frame = {HDR_VAL, FIXED_PAY};
        unique case (mode)
            MODE_FIXED: frame = {HDR_VAL, FIXED_PAY};
            MODE_COUNT: frame = {HDR_VAL, ctr_pay};
            MODE_PRBS:  frame = {HDR_VAL, prbs_pay};
            default:    frame = {HDR_VAL, FIXED_PAY};
        endcase
    end
endmodule

// File: rtl/lpu_check.sv
module lpu_check
    import lpu_pkg::*;
#(
    parameter int ERR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_en,
    input  logic [FRAME_W-1:0] rx_frame,
    input  logic               rx_valid,
    input  logic               err_clear,
    output logic [ERR_W-1:0]   err_count
);
    logic [ERR_W-1:0] err_q;
    logic [PC_W-1:0]  miss;
    logic [ERR_W:0]   sum;

    assign miss = ones_in(rx_frame[PAY_W-1:0] ^ FIXED_PAY);
    assign sum  = {1'b0, err_q} + (ERR_W+1)'(miss);

    always_ff @(posedge clk) begin
        if (!rst_n)                 err_q <= '0;
        else if (err_clear)         err_q <= '0;
        else if (chk_en && rx_valid) err_q <= sum[ERR_W] ? '1 : sum[ERR_W-1:0];
    end

    assign err_count = err_q;
endmodule

// File: rtl/link_pattern_unit.sv
module link_pattern_unit
    import lpu_pkg::*;
#(
    parameter int ERR_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     pat_sel,
    output logic [119:0]   tx_frame,
    input  logic [119:0]   rx_frame,
    input  logic           rx_valid,
    input  logic           err_clear,
    output logic [ERR_W-1:0] err_count
);
    mode_e mode_q;
    logic  chk_en;

    lpu_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel),
        .mode_q(mode_q), .chk_en(chk_en)
    );

    lpu_gen i_gen (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .frame(tx_frame)
    );

    lpu_check #(.ERR_W(ERR_W)) i_check (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .rx_frame(rx_frame),
        .rx_valid(rx_valid), .err_clear(err_clear), .err_count(err_count)
    );
endmodule

// File: rtl/lpu_props.sv
module lpu_props
    import lpu_pkg::*;
#(
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [119:0]     tx_frame,
    input logic             rx_valid,
    input logic             err_clear,
    input logic [ERR_W-1:0] err_count,
    input mode_e            mode
);
    p_header_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame[119:116] == HDR_VAL);

    p_ctr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_COUNT && mode == MODE_COUNT && $past(rst_n))
        |-> tx_frame[29:0] == $past(tx_frame[29:0]) + 30'd1);

    p_prbs_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PRBS) |-> (tx_frame[6:0] != 7'd0 && tx_frame[115:112] == 4'd0));

    p_no_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !err_clear) |=> $stable(err_count));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_FIXED && !err_clear) |=> $stable(err_count));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_clear) |=> err_count >= $past(err_count));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_clear |=> err_count == '0);
endmodule

bind link_pattern_unit lpu_props #(.ERR_W(ERR_W)) i_props (
    .clk(clk), .rst_n(rst_n), .tx_frame(tx_frame), .rx_valid(rx_valid),
    .err_clear(err_clear), .err_count(err_count), .mode(mode_q)
);

// File: tb/test_link_pattern_unit.sv
`timescale 1ns/1ps
module test_link_pattern_unit;
    localparam int EW = 16;
    localparam logic [115:0] FIX = 116'hAAA_BBBB_AAAA_BBBB_AAAA_BBBB_AAAA_BB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    pat_sel = 2'b00;
    logic [119:0]  tx_frame;
    logic [119:0]  rx_frame = '0;
    logic          rx_valid = 1'b0;
    logic          err_clear = 1'b0;
    logic [EW-1:0] err_count;

    int checks = 0;
    int failures = 0;

    // bench model: mode 0 fixed, 1 counter, 2 prbs
    int            m_mode = 0;
    logic [29:0]   m_ctr = '0;
    logic [6:0]    m_prbs = 7'h7F;
    logic [EW-1:0] m_err = '0;

    always #10 clk = ~clk;

    link_pattern_unit #(.ERR_W(EW)) i_link_pattern_unit (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .tx_frame(tx_frame),
        .rx_frame(rx_frame), .rx_valid(rx_valid), .err_clear(err_clear),
        .err_count(err_count)
    );

    function automatic logic [119:0] exp_frame(int md, logic [29:0] c, logic [6:0] p);
        logic [111:0] rep;
        for (int k = 0; k < 16; k++) rep[k*7 +: 7] = p;
        case (md)
            1:       return {4'b0101, c[25:0], c, c, c};
            2:       return {4'b0101, 4'h0, rep};
            default: return {4'b0101, FIX};
        endcase
    endfunction

    function automatic int sel_to_mode(logic [1:0] s);
        return (s == 2'b01) ? 1 : (s == 2'b10) ? 2 : 0;
    endfunction

    task automatic check_frame(string req);
        logic [119:0] e;
        e = exp_frame(m_mode, m_ctr, m_prbs);
        checks++;
        if (tx_frame !== e) begin
            failures++;
            $display("FAIL %s tx_frame actual=%h expected=%h", req, tx_frame, e);
        end
    endtask

    task automatic check_err(string req);
        checks++;
        if (err_count !== m_err) begin
            failures++;
            $display("FAIL %s err_count actual=%0d expected=%0d", req, err_count, m_err);
        end
    endtask

    // one clock edge; model updated from the inputs seen at that edge
    task automatic tick();
        int s;
        @(posedge clk);
        if (!rst_n) begin
            m_mode = 0; m_ctr = '0; m_prbs = 7'h7F; m_err = '0;
        end else begin
            if (err_clear) m_err = '0;
            else if (rx_valid && m_mode == 0) begin
                s = int'(m_err) + $countones(rx_frame[115:0] ^ FIX);
                m_err = (s > (2**EW - 1)) ? '1 : EW'(s);
            end
            m_mode = sel_to_mode(pat_sel);
            m_ctr  = m_ctr + 30'd1;
            m_prbs = {m_prbs[5:0], m_prbs[6] ^ m_prbs[5]};
        end
        @(negedge clk);
    endtask

    function automatic logic [115:0] flips(int n);
        logic [115:0] m = '0;
        int placed = 0;
        while (placed < n) begin
            int b = $urandom_range(115, 0);
            if (!m[b]) begin m[b] = 1'b1; placed++; end
        end
        return m;
    endfunction

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        // R12, R1: reset state
        tick(); tick();
        check_frame("R12/R1 reset frame");
        check_err("R12 reset count");
        @(negedge clk); rst_n = 1'b1;

        // R3, R7: clean frame adds nothing, three flips add three
        rx_valid = 1'b1; rx_frame = {4'b0101, FIX};
        tick(); check_err("R7 clean frame"); check_frame("R3 fixed payload");
        rx_frame = {4'b0101, FIX ^ flips(3)};
        tick(); check_err("R7 three flips");
        // R7: header bits ignored
        rx_frame = {4'b1010, FIX};
        tick(); check_err("R7 header ignored");
        // R8: invalid frame ignored
        rx_valid = 1'b0; rx_frame = ~rx_frame;
        tick(); check_err("R8 invalid ignored");

        // R2, R4: counter mode
        pat_sel = 2'b01;
        tick(); check_frame("R2/R4 counter frame");
        rx_valid = 1'b1;
        tick(); check_frame("R4 counter advance"); check_err("R9 counter mode idle");
        // R5, R6: PRBS mode
        pat_sel = 2'b10;
        tick(); check_frame("R5/R6 prbs frame"); check_err("R9 prbs mode idle");
        tick(); check_frame("R6 prbs advance");
        // R2: code 11 gives constant payload
        pat_sel = 2'b11; rx_valid = 1'b0;
        tick(); check_frame("R2 code 11 fixed");

        // R11: clear wins over accumulation
        pat_sel = 2'b00; rx_valid = 1'b1; rx_frame = {4'b0101, ~FIX};
        tick();
        err_clear = 1'b1;
        tick(); check_err("R11 clear priority");
        err_clear = 1'b0;

        // random mix
        for (int i = 0; i < 800; i++) begin
            int r = $urandom_range(9, 0);
            pat_sel   = (r < 5) ? 2'b00 : 2'($urandom_range(3, 0));
            rx_valid  = ($urandom_range(3, 0) != 0);
            err_clear = ($urandom_range(40, 0) == 0);
            if ($urandom_range(4, 0) == 0) rx_frame = {$urandom, $urandom, $urandom, $urandom}[119:0];
            else rx_frame = {4'($urandom), FIX ^ flips($urandom_range(5, 0))};
            tick();
            check_frame("R2/R3/R4/R5 random frame");
            check_err("R7/R8/R9/R11 random count");
        end

        // R10: saturate with inverted payloads
        err_clear = 1'b0; pat_sel = 2'b00; rx_valid = 1'b1; rx_frame = {4'b0101, ~FIX};
        for (int i = 0; i < 600; i++) tick();
        check_err("R10 saturated");
        checks++;
        if (err_count !== '1) begin
            failures++;
            $display("FAIL R10 not all ones actual=%h expected=%h", err_count, {EW{1'b1}});
        end
        tick(); check_err("R10 held at all ones");
        err_clear = 1'b1;
        tick(); check_err("R11 clear after saturation");
        err_clear = 1'b0; rx_valid = 1'b0;
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule